// File: doc/BRIEF.md
# Flash Command Cycle Decoder

This block sits on the write side of a parallel flash-style bus. It watches each write strobe together with its word address and data word, and it follows the multi-cycle unlock sequences that a host writes to start array operations. When a sequence completes, the block hands a decoded request to a downstream operation engine. The request can be a word program with its address and data, a whole-chip erase, or a sector erase with its target address. The block also reports, for each bank, whether that bank is still in plain read mode.

The decoder supports a bypass mode. In this mode the unlock preamble is skipped, so a program or a chip erase takes only two write cycles. The host can enter bypass mode with a command, or a dedicated accelerate input can force it with no command at all. A two-cycle reset sequence leaves bypass mode. After the block issues a chip erase, it ignores all writes until the engine reports that the erase is finished.

The engine returns a busy flag. A request is only issued while that flag is low. A synchronous reset abandons any sequence and any chip erase in progress at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While and right after reset, all three request outputs are low, `bypass_mode` is 0 and every bit of `bank_read` is 1.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by one more write produce `prog_req` high for exactly one cycle, right after that last write, with `op_addr`/`op_data` equal to that write's address and data. The low 8 data bits carry command codes, and unlock addresses compare the low 11 address bits.
- R3: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produce a one-cycle `chip_erase_req`.
- R4: The same five-cycle prefix followed by 30h at any address produces a one-cycle `sect_erase_req`, and `op_addr` equals that address.
- R5: AAh@555h, 55h@2AAh, 20h@555h sets `bypass_mode`. In bypass mode, A0h followed by one data write issues a program, and 80h followed by 10h issues a chip erase. Addresses are ignored in both.
- R6: In bypass mode, a write of 90h followed by a write of 00h clears `bypass_mode`. If the second write is 90h followed by any other data, the block stays in bypass mode.
- R7: With `accel` high, `bypass_mode` reads 1 from the next cycle on and two-cycle programs are accepted. While `accel` is high, the exit sequence has no effect. When `accel` drops in a block that was not put into bypass mode by a command, `bypass_mode` returns to 0 one cycle later.
- R8: A write that does not match the next expected cycle abandons the sequence. No request is issued and the block goes back to read mode, or to bypass idle if bypass mode is active.
- R9: After a chip erase request, all `bank_read` bits are 0 and all writes are ignored. This lasts until `eng_busy` has been high and then falls. One cycle after the fall, the block is back in idle.
- R10: If `eng_busy` is high on the final write of a sequence, no request is issued and the sequence is dropped.
- R11: Reset during a running chip erase returns the block to read mode at once, with every bit of `bank_read` set to 1.
- R12: While a sequence or bypass mode is active, the `bank_read` bit of the bank addressed by the sequence's first write is 0. The bank index is the top BANK_BITS bits of the address. All other bits stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Data word of the write |
| accel | input | 1 | Forces bypass mode while high |
| eng_busy | input | 1 | Operation engine busy flag |
| prog_req | output | 1 | One-cycle program request |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| op_addr | output | AW | Program or sector erase address |
| op_data | output | DW | Program data |
| bypass_mode | output | 1 | Bypass mode active |
| bank_read | output | 2**BANK_BITS | Per-bank read mode flags |

## Verification
The bench sends a program preamble whose last unlock cycle is at the wrong address, and a six-cycle erase that ends with 10h at an address other than 555h. A decoder that is too lenient would issue an operation in both cases. Writes are sent while a chip erase is running, and a final cycle is sent while the engine is busy. Either mistake in the design would show up as a stray request pulse.

The bypass exit is tried first with a wrong second data word and then with the right one. It is also tried while `accel` holds bypass mode. A decoder with a faulty exit would leave bypass mode too early, or stay in it too long. Reset in the middle of a chip erase and the per-bank read flags during a sequence are checked to catch a stuck erase state or the wrong bank being marked.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_ESET, S_EUNL1, S_EUNL2,
    S_PGM, S_BERASE, S_BEXIT, S_CERUN
  } fcd_state_e;

  localparam logic [7:0] CMD_KEY_A   = 8'hAA;
  localparam logic [7:0] CMD_KEY_B   = 8'h55;
  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_BYP_IN  = 8'h20;
  localparam logic [7:0] CMD_BYP_OUT = 8'h90;
  localparam logic [7:0] CMD_BYP_FIN = 8'h00;

  localparam int         KEY_BITS    = 11;
  localparam logic [KEY_BITS-1:0] ADR_KEY_A = 11'h555;
  localparam logic [KEY_BITS-1:0] ADR_KEY_B = 11'h2AA;
endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [KEY_BITS-1:0]  key_addr,
  input  logic [BANK_BITS-1:0] wr_bank,
  input  logic [7:0]           cmd,
  input  logic                 accel_q,
  input  logic                 eng_busy,
  output fcd_state_e           state_o,
  output logic                 byp_o,
  output logic [BANK_BITS-1:0] act_bank_o,
  output logic                 iss_prog,
  output logic                 iss_ce,
  output logic                 iss_se
);
  fcd_state_e           state, nxt;
  logic                 byp_q, byp_n, busy_q;
  logic [BANK_BITS-1:0] bank_q, bank_n;
  logic                 at_a, at_b, byp_eff;

  assign at_a    = (key_addr == ADR_KEY_A);
  assign at_b    = (key_addr == ADR_KEY_B);
  assign byp_eff = byp_q | accel_q;

  always_comb begin
    nxt      = state;
    byp_n    = byp_q;
    bank_n   = bank_q;
    iss_prog = 1'b0;
    iss_ce   = 1'b0;
    iss_se   = 1'b0;
    unique case (state)
      S_IDLE: if (wr_en) begin
        bank_n = wr_bank;
        if (byp_eff) begin
          if (cmd == CMD_PROG)                     nxt = S_PGM;
          else if (cmd == CMD_SETUP)               nxt = S_BERASE;
          else if (cmd == CMD_BYP_OUT && !accel_q) nxt = S_BEXIT;
        end else if (cmd == CMD_KEY_A && at_a) begin
          nxt = S_UNL1;
        end
      end
      S_UNL1: if (wr_en) nxt = (cmd == CMD_KEY_B && at_b) ? S_UNL2 : S_IDLE;
      S_UNL2: if (wr_en) begin
        nxt = S_IDLE;
        if (at_a) begin
          if (cmd == CMD_PROG)        nxt = S_PGM;
          else if (cmd == CMD_SETUP)  nxt = S_ESET;
          else if (cmd == CMD_BYP_IN) byp_n = 1'b1;
        end
      end
      S_ESET:  if (wr_en) nxt = (cmd == CMD_KEY_A && at_a) ? S_EUNL1 : S_IDLE;
      S_EUNL1: if (wr_en) nxt = (cmd == CMD_KEY_B && at_b) ? S_EUNL2 : S_IDLE;
      S_EUNL2: if (wr_en) begin
        nxt = S_IDLE;
        if (!eng_busy) begin
          if (cmd == CMD_CHIP && at_a) begin
            iss_ce = 1'b1;
            nxt    = S_CERUN;
          end else if (cmd == CMD_SECT) begin
            iss_se = 1'b1;
          end
        end
      end
      S_PGM: if (wr_en) begin
        nxt      = S_IDLE;
        iss_prog = !eng_busy;
      end
      S_BERASE: if (wr_en) begin
        nxt = S_IDLE;
        if (cmd == CMD_CHIP && !eng_busy) begin
          iss_ce = 1'b1;
          nxt    = S_CERUN;
        end
      end
      S_BEXIT: if (wr_en) begin
        nxt = S_IDLE;
        if (cmd == CMD_BYP_FIN) byp_n = 1'b0;
      end
      S_CERUN: if (busy_q && !eng_busy) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      byp_q  <= 1'b0;
      bank_q <= '0;
      busy_q <= 1'b0;
    end else begin
      state  <= nxt;
      byp_q  <= byp_n;
      bank_q <= bank_n;
      busy_q <= eng_busy;
    end
  end

  assign state_o    = state;
  assign byp_o      = byp_q;
  assign act_bank_o = bank_q;

  // R9: engine still busy keeps the erase-running state
  assert_cerun_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_CERUN && eng_busy) |=> (state == S_CERUN));
endmodule

// File: rtl/fcd_req.sv
module fcd_req #(
  parameter int AW = 23,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_prog,
  input  logic          iss_ce,
  input  logic          iss_se,
  input  logic          eng_busy,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          prog_req,
  output logic          ce_req,
  output logic          se_req,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_req <= 1'b0;
      ce_req   <= 1'b0;
      se_req   <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      prog_req <= iss_prog;
      ce_req   <= iss_ce;
      se_req   <= iss_se;
      if (iss_prog || iss_se) op_addr <= wr_addr;
      if (iss_prog)           op_data <= wr_data;
    end
  end

  assert_busy_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (prog_req || ce_req || se_req) |-> !$past(eng_busy));
  assert_one_req_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_req, ce_req, se_req}));
  assert_prog_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    prog_req |=> !prog_req);
endmodule

// File: rtl/fcd_bank.sv
module fcd_bank
  import fcd_pkg::*;
#(
  parameter int BANK_BITS = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  fcd_state_e           state,
  input  logic [BANK_BITS-1:0] act_bank,
  input  logic                 byp_eff,
  output logic [NB-1:0]        bank_read
);
  logic ce_run, engaged;
  assign ce_run  = (state == S_CERUN);
  assign engaged = (state != S_IDLE) || byp_eff;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_read[b] = !(ce_run || (engaged && act_bank == BANK_BITS'(b)));
  end

  assert_single_bank_R12: assert property (@(posedge clk) disable iff (rst)
    !ce_run |-> ($countones(~bank_read) <= 1));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int AW = 23,
  parameter int DW = 16,
  parameter int BANK_BITS = 2,
  localparam int NB = 1 << BANK_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          accel,
  input  logic          eng_busy,
  output logic          prog_req,
  output logic          chip_erase_req,
  output logic          sect_erase_req,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          bypass_mode,
  output logic [NB-1:0] bank_read
);
  fcd_state_e           state;
  logic                 accel_q, byp_q;
  logic [BANK_BITS-1:0] act_bank;
  logic                 iss_prog, iss_ce, iss_se;

  always_ff @(posedge clk) begin
    if (rst) accel_q <= 1'b0;
    else     accel_q <= accel;
  end

  assign bypass_mode = byp_q | accel_q;

  fcd_seq #(.BANK_BITS(BANK_BITS)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .key_addr(wr_addr[KEY_BITS-1:0]),
    .wr_bank(wr_addr[AW-1 -: BANK_BITS]),
    .cmd(wr_data[7:0]), .accel_q(accel_q), .eng_busy(eng_busy),
    .state_o(state), .byp_o(byp_q), .act_bank_o(act_bank),
    .iss_prog(iss_prog), .iss_ce(iss_ce), .iss_se(iss_se)
  );

  fcd_req #(.AW(AW), .DW(DW)) u_req (
    .clk(clk), .rst(rst), .iss_prog(iss_prog), .iss_ce(iss_ce),
    .iss_se(iss_se), .eng_busy(eng_busy), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_req(prog_req), .ce_req(chip_erase_req),
    .se_req(sect_erase_req), .op_addr(op_addr), .op_data(op_data)
  );

  fcd_bank #(.BANK_BITS(BANK_BITS)) u_bank (
    .clk(clk), .rst(rst), .state(state), .act_bank(act_bank),
    .byp_eff(bypass_mode), .bank_read(bank_read)
  );

  assert_accel_bypass_R7: assert property (@(posedge clk) disable iff (rst)
    accel |=> bypass_mode);
  assert_erase_ignores_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_CERUN) |=> !(prog_req || chip_erase_req || sect_erase_req));
endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23;
  localparam int DW = 16;
  localparam int BB = 2;
  localparam int NB = 1 << BB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          accel = 1'b0;
  logic          eng_busy = 1'b0;
  logic          prog_req, chip_erase_req, sect_erase_req, bypass_mode;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic [NB-1:0] bank_read;
  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW), .BANK_BITS(BB)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .accel(accel), .eng_busy(eng_busy), .prog_req(prog_req),
    .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
    .op_addr(op_addr), .op_data(op_data), .bypass_mode(bypass_mode),
    .bank_read(bank_read)
  );

  function automatic logic [AW-1:0] ba(int bank, int low);
    return AW'((bank << (AW - BB)) | low);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic no_req(string tag);
    chk(tag, {prog_req, chip_erase_req, sect_erase_req}, 3'b000);
  endtask

  task automatic preamble(int b);
    wr(ba(b, 'h555), 16'h00AA);
    wr(ba(b, 'h2AA), 16'h0055);
  endtask

  task automatic erase_prefix(int b);
    preamble(b);
    wr(ba(b, 'h555), 16'h0080);
    preamble(b);
  endtask

  task automatic finish_erase();
    @(negedge clk) eng_busy = 1'b1;
    step();
    @(negedge clk) eng_busy = 1'b0;
    step();
  endtask

  task automatic t_reset();
    no_req("R1 requests");
    chk("R1 bypass", bypass_mode, 0);
    chk("R1 bank_read", bank_read, 4'hF);
  endtask

  task automatic t_program();
    preamble(1);
    wr(ba(1, 'h555), 16'h00A0);
    chk("R12 bank1 engaged", bank_read, 4'b1101);
    wr(ba(1, 'h1234), 16'hBEEF);
    chk("R2 prog_req", prog_req, 1);
    chk("R2 op_addr", op_addr, ba(1, 'h1234));
    chk("R2 op_data", op_data, 16'hBEEF);
    step();
    chk("R2 pulse ends", prog_req, 0);
    chk("R2 back to read", bank_read, 4'hF);
  endtask

  task automatic t_chip();
    erase_prefix(0);
    wr(ba(0, 'h555), 16'h0010);
    chk("R3 chip_erase_req", chip_erase_req, 1);
    step();
    chk("R3 pulse ends", chip_erase_req, 0);
    chk("R9 all banks busy", bank_read, 4'h0);
    @(negedge clk) eng_busy = 1'b1;
    preamble(0);
    wr(ba(0, 'h555), 16'h00A0);
    wr(ba(0, 'h77), 16'h1111);
    no_req("R9 writes ignored");
    chk("R9 still running", bank_read, 4'h0);
    @(negedge clk) eng_busy = 1'b0;
    step();
    chk("R9 back to read", bank_read, 4'hF);
  endtask

  task automatic t_sector();
    erase_prefix(2);
    wr(ba(2, 'h4000), 16'h0030);
    chk("R4 sect_erase_req", sect_erase_req, 1);
    chk("R4 op_addr", op_addr, ba(2, 'h4000));
    step();
    chk("R4 pulse ends", sect_erase_req, 0);
  endtask

  task automatic t_mismatch();
    preamble(0);
    wr(ba(0, 'h2AA), 16'h00A0);
    wr(ba(0, 'h50), 16'h2222);
    no_req("R8 bad program address");
    chk("R8 read mode", bank_read, 4'hF);
    erase_prefix(3);
    wr(ba(3, 'h123), 16'h0010);
    no_req("R8 bad chip erase address");
    chk("R8 read mode after erase", bank_read, 4'hF);
  endtask

  task automatic t_bypass();
    preamble(3);
    wr(ba(3, 'h555), 16'h0020);
    chk("R5 bypass entered", bypass_mode, 1);
    wr(ba(0, 'h0), 16'h00A0);
    wr(ba(0, 'h99), 16'h5A5A);
    chk("R5 two-cycle program", prog_req, 1);
    chk("R5 program data", op_data, 16'h5A5A);
    wr(ba(1, 'h3), 16'h0080);
    wr(ba(1, 'h7), 16'h0010);
    chk("R5 two-cycle chip erase", chip_erase_req, 1);
    finish_erase();
    chk("R5 still bypass after erase", bypass_mode, 1);
    wr(ba(3, 'h0), 16'h0090);
    wr(ba(3, 'h0), 16'h0055);
    chk("R6 wrong exit keeps bypass", bypass_mode, 1);
    wr(ba(3, 'h0), 16'h0090);
    wr(ba(0, 'h0), 16'h0000);
    chk("R6 exit clears bypass", bypass_mode, 0);
    chk("R6 read mode", bank_read, 4'hF);
  endtask

  task automatic t_busy();
    preamble(2);
    wr(ba(2, 'h555), 16'h00A0);
    @(negedge clk) eng_busy = 1'b1;
    wr(ba(2, 'h10), 16'h3333);
    no_req("R10 busy blocks request");
    @(negedge clk) eng_busy = 1'b0;
    chk("R10 sequence dropped", bank_read, 4'hF);
  endtask

  task automatic t_accel();
    @(negedge clk) accel = 1'b1;
    step();
    chk("R7 accel forces bypass", bypass_mode, 1);
    wr(ba(1, 'h0), 16'h00A0);
    wr(ba(1, 'h42), 16'h0F0F);
    chk("R7 accel program", prog_req, 1);
    wr(ba(1, 'h0), 16'h0090);
    wr(ba(1, 'h0), 16'h0000);
    chk("R7 exit ignored under accel", bypass_mode, 1);
    @(negedge clk) accel = 1'b0;
    step();
    chk("R7 accel release", bypass_mode, 0);
  endtask

  task automatic t_reset_erase();
    erase_prefix(1);
    wr(ba(1, 'h555), 16'h0010);
    @(negedge clk) eng_busy = 1'b1;
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk("R11 reset ends erase", bank_read, 4'hF);
    no_req("R11 no request");
    @(negedge clk) eng_busy = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst = 1'b0;
    step();
    t_program();
    t_chip();
    t_sector();
    t_mismatch();
    t_bypass();
    t_busy();
    t_accel();
    t_reset_erase();
    step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule